// File: doc/BRIEF.md
# Privileged Control and Special-Register Unit

This block sits beside the execute stage of a small in-order core and handles the core's custom system instructions. It holds a one-bit privilege flag (1 = privileged, 0 = user) and a small file of special registers. Each accepted instruction word is matched against a set of fixed system encodings and a few opcode classes. From that match the block decides whether to redirect the PC, return special-register data to the writeback path, pulse a send or receive strobe toward the external I/O port, or raise an illegal-instruction trap.

The pipeline supplies the instruction word, its PC, the value of the regular register the instruction names, and an exception request from elsewhere in the core. The redirect is produced in the same cycle as the instruction. Every change to the privilege flag or to a special register takes effect at the next clock edge. Special register 0 holds the trap return address. Special register 4 is the I/O data register: its contents are what gets sent, and received values are written into it.

Top module: `priv_sys_unit`

## Requirements
- R1: After reset `privMode` is 1 and every special register is zero, so `ioSendData` shows 0 and special-register moves return 0.
- R2: Word 0x0000007F (trap return) in privileged mode drives `redirValid` with `redirPc` equal to special register 0 in the same cycle, and `privMode` reads 0 from the next edge.
- R3: Trap return, print (0x0200007D) or read (0x0400007D) in user mode raises `illegalExc`, redirects to `HANDLER_PC`, produces no I/O strobe, stores `instPc` into special register 0 and sets `privMode` to 1.
- R4: Print in privileged mode pulses `ioSend` for that cycle. `ioSendData` always shows special register 4.
- R5: Read in privileged mode pulses `ioRecv`, and special register 4 takes `ioRxData` at the next edge.
- R6: In user mode, system call 0x00600073 gives the print effect and 0x00700073 gives the read effect. Both also trap: they redirect to `HANDLER_PC`, store `instPc`+4 into special register 0 and set `privMode`. In privileged mode either word is illegal, as in R3.
- R7: Opcode 0101111 with bits [31:25] = 0000000 raises `wbValid`, with `wbIdx` = bits [11:7] and `wbData` = special register selected by bits [21:20].
- R8: Opcode 0101111 with bits [31:25] = 0000001 writes `regRdata` into the special register selected by bits [11:7] at the next edge. An index of `SREG_NUM` or above writes nothing.
- R9: Opcode 1101111 redirects to `regRdata` in either mode. Bits [31:7] do not affect the decode.
- R10: `excReq` overrides any instruction in the same cycle. The block redirects to `HANDLER_PC`, stores `instPc` into special register 0 and sets `privMode`. There is no writeback, no I/O strobe and no `illegalExc`.
- R11: With `instValid` low, or with a word that matches no class above, the block gives no redirect, writeback, strobe or state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instValid | input | 1 | Instruction word is accepted this cycle |
| instWord | input | 32 | Instruction word |
| instPc | input | XLEN | PC of the instruction |
| regRdata | input | XLEN | Value of the regular register the instruction names |
| excReq | input | 1 | Exception request from the rest of the core |
| ioRxData | input | XLEN | Value offered by the external I/O port |
| redirValid | output | 1 | PC redirect this cycle |
| redirPc | output | XLEN | Redirect target |
| wbValid | output | 1 | Special-register read result for writeback |
| wbIdx | output | 5 | Regular destination register index |
| wbData | output | XLEN | Special-register read data |
| ioSend | output | 1 | Send strobe to the I/O port |
| ioRecv | output | 1 | Receive strobe to the I/O port |
| ioSendData | output | XLEN | Special register 4, the outgoing data |
| illegalExc | output | 1 | Privileged instruction attempted in user mode |
| privMode | output | 1 | Current privilege flag |

## Verification
A user-mode receive system call does two things in one cycle. It writes the received value into the I/O register and the return address into register 0. The bench issues it and then reads both back: register 4 through `ioSendData`, and register 0 through a move and a later trap return. An exception request is also driven in the same cycle as a register write, a print and a trap return. In each case the bench expects the trap alone, with the instruction's effect absent. A behavioural reference model compares every output on every cycle, across directed sequences and a long random mix.

// File: rtl/priv_sys_pkg.sv
package priv_sys_pkg;

  localparam logic [31:0] WORD_TRAP_RET = 32'h0000_007F;
  localparam logic [31:0] WORD_PRINT    = 32'h0200_007D;
  localparam logic [31:0] WORD_READ     = 32'h0400_007D;
  localparam logic [31:0] WORD_SYS_TX   = 32'h0060_0073;
  localparam logic [31:0] WORD_SYS_RX   = 32'h0070_0073;

  localparam logic [6:0] OPC_SREG_MOVE = 7'b0101111;
  localparam logic [6:0] OPC_REG_JUMP  = 7'b1101111;
  localparam logic [6:0] F7_SREG_TO_REG = 7'b0000000;
  localparam logic [6:0] F7_REG_TO_SREG = 7'b0000001;

  localparam int RET_IDX = 0;
  localparam int IO_IDX  = 4;

  // Strobes from the decode/privilege control to the state datapath
  typedef struct packed {
    logic trapEnter;
    logic trapNextPc;
    logic trapRet;
    logic jumpReg;
    logic moveFrom;
    logic moveTo;
    logic ioSend;
    logic ioRecv;
    logic illegal;
  } ctrl_strb_t;

endpackage

// File: rtl/priv_sys_ctrl.sv
module priv_sys_ctrl
  import priv_sys_pkg::*;
(
  input  logic        instValid,
  input  logic [31:0] instWord,
  input  logic        excReq,
  input  logic        privMode,
  output ctrl_strb_t  strb
);

  logic isTrapRet, isPrint, isRead, isSysTx, isSysRx;
  logic isPrivOp, isSysCall, isMove;

  always_comb begin
    isTrapRet = (instWord == WORD_TRAP_RET);
    isPrint   = (instWord == WORD_PRINT);
    isRead    = (instWord == WORD_READ);
    isSysTx   = (instWord == WORD_SYS_TX);
    isSysRx   = (instWord == WORD_SYS_RX);
    isPrivOp  = isTrapRet | isPrint | isRead;
    isSysCall = isSysTx | isSysRx;
    isMove    = (instWord[6:0] == OPC_SREG_MOVE);
  end

  always_comb begin
    strb = '0;
    if (excReq) begin
      // external exception wins; instruction is squashed
      strb.trapEnter = 1'b1;
    end else if (instValid) begin
      if (isPrivOp) begin
        if (privMode) begin
          strb.trapRet = isTrapRet;
          strb.ioSend  = isPrint;
          strb.ioRecv  = isRead;
        end else begin
          strb.illegal   = 1'b1;
          strb.trapEnter = 1'b1;
        end
      end else if (isSysCall) begin
        strb.trapEnter = 1'b1;
        if (!privMode) begin
          strb.trapNextPc = 1'b1;
          strb.ioSend     = isSysTx;
          strb.ioRecv     = isSysRx;
        end else begin
          strb.illegal = 1'b1;
        end
      end else if (isMove) begin
        strb.moveFrom = (instWord[31:25] == F7_SREG_TO_REG);
        strb.moveTo   = (instWord[31:25] == F7_REG_TO_SREG);
      end else if (instWord[6:0] == OPC_REG_JUMP) begin
        strb.jumpReg = 1'b1;
      end
    end
  end

endmodule

// File: rtl/priv_sys_dp.sv
module priv_sys_dp
  import priv_sys_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          SREG_NUM   = 8,
  parameter logic [XLEN-1:0] HANDLER_PC = 'h200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctrl_strb_t      strb,
  input  logic [4:0]      moveDst,
  input  logic [1:0]      moveSrc,
  input  logic [XLEN-1:0] instPc,
  input  logic [XLEN-1:0] regRdata,
  input  logic [XLEN-1:0] ioRxData,
  output logic            redirValid,
  output logic [XLEN-1:0] redirPc,
  output logic [XLEN-1:0] wbData,
  output logic [XLEN-1:0] ioSendData,
  output logic            privMode
);

  localparam int IDXW = $clog2(SREG_NUM);

  logic [XLEN-1:0] sreg  [SREG_NUM];
  logic [XLEN-1:0] wrVal [SREG_NUM];
  logic [SREG_NUM-1:0] wrEn;
  logic [XLEN-1:0] trapPc;
  logic pswQ;

  assign trapPc = instPc + (strb.trapNextPc ? XLEN'(4) : '0);

  // one write-port selector per special register
  for (genvar i = 0; i < SREG_NUM; i++) begin : g_wr
    logic hitTrap, hitRecv, hitMove;
    assign hitTrap  = (i == RET_IDX) && strb.trapEnter;
    assign hitRecv  = (i == IO_IDX) && strb.ioRecv;
    assign hitMove  = strb.moveTo && (moveDst == 5'(i));
    assign wrEn[i]  = hitTrap | hitRecv | hitMove;
    assign wrVal[i] = hitTrap ? trapPc : (hitRecv ? ioRxData : regRdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SREG_NUM; i++) sreg[i] <= '0;
    end else begin
      for (int i = 0; i < SREG_NUM; i++)
        if (wrEn[i]) sreg[i] <= wrVal[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pswQ <= 1'b1;
    else if (strb.trapEnter) pswQ <= 1'b1;
    else if (strb.trapRet)   pswQ <= 1'b0;
  end

  always_comb begin
    redirValid = strb.trapEnter | strb.trapRet | strb.jumpReg;
    if (strb.trapEnter)    redirPc = HANDLER_PC;
    else if (strb.trapRet) redirPc = sreg[RET_IDX];
    else                   redirPc = regRdata;
  end

  assign wbData     = sreg[IDXW'(moveSrc)];
  assign ioSendData = sreg[IO_IDX];
  assign privMode   = pswQ;

endmodule

// File: rtl/priv_sys_unit.sv
module priv_sys_unit
  import priv_sys_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          SREG_NUM   = 8,
  parameter logic [XLEN-1:0] HANDLER_PC = 'h200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instValid,
  input  logic [31:0]     instWord,
  input  logic [XLEN-1:0] instPc,
  input  logic [XLEN-1:0] regRdata,
  input  logic            excReq,
  input  logic [XLEN-1:0] ioRxData,
  output logic            redirValid,
  output logic [XLEN-1:0] redirPc,
  output logic            wbValid,
  output logic [4:0]      wbIdx,
  output logic [XLEN-1:0] wbData,
  output logic            ioSend,
  output logic            ioRecv,
  output logic [XLEN-1:0] ioSendData,
  output logic            illegalExc,
  output logic            privMode
);

  ctrl_strb_t strb;

  priv_sys_ctrl ctrl_i (
    .instValid (instValid),
    .instWord  (instWord),
    .excReq    (excReq),
    .privMode  (privMode),
    .strb      (strb)
  );

  priv_sys_dp #(
    .XLEN       (XLEN),
    .SREG_NUM   (SREG_NUM),
    .HANDLER_PC (HANDLER_PC)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .moveDst    (instWord[11:7]),
    .moveSrc    (instWord[21:20]),
    .instPc     (instPc),
    .regRdata   (regRdata),
    .ioRxData   (ioRxData),
    .redirValid (redirValid),
    .redirPc    (redirPc),
    .wbData     (wbData),
    .ioSendData (ioSendData),
    .privMode   (privMode)
  );

  assign wbValid    = strb.moveFrom;
  assign wbIdx      = instWord[11:7];
  assign ioSend     = strb.ioSend;
  assign ioRecv     = strb.ioRecv;
  assign illegalExc = strb.illegal;

endmodule

// File: rtl/priv_sys_chk.sv
module priv_sys_chk #(
  parameter int          XLEN       = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 'h200
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instValid,
  input logic [31:0]     instWord,
  input logic            excReq,
  input logic [XLEN-1:0] ioRxData,
  input logic            redirValid,
  input logic [XLEN-1:0] redirPc,
  input logic            wbValid,
  input logic [4:0]      wbIdx,
  input logic            ioSend,
  input logic            ioRecv,
  input logic [XLEN-1:0] ioSendData,
  input logic            illegalExc,
  input logic            privMode
);

  assert_illegal_sets_priv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegalExc |=> privMode);

  assert_illegal_traps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegalExc |-> (redirValid && redirPc == HANDLER_PC && !ioSend && !ioRecv));

  assert_ret_drops_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (instValid && !excReq && privMode && instWord == 32'h0000_007F) |=> !privMode);

  assert_exc_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
    excReq |-> (redirValid && redirPc == HANDLER_PC && !wbValid && !ioSend && !ioRecv && !illegalExc));

  assert_user_io_traps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ioSend || ioRecv) && !privMode) |-> (redirValid && redirPc == HANDLER_PC));

  assert_io_one_way_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ioSend && ioRecv));

  assert_recv_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ioRecv |=> (ioSendData == $past(ioRxData)));

  assert_move_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> (instValid && wbIdx == instWord[11:7]));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!instValid && !excReq) |-> (!redirValid && !wbValid && !ioSend && !ioRecv && !illegalExc));

  assert_idle_keeps_priv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!instValid && !excReq) |=> (privMode == $past(privMode)));

endmodule

bind priv_sys_unit priv_sys_chk #(.XLEN(XLEN), .HANDLER_PC(HANDLER_PC)) chk_i (.*);

// File: tb/priv_sys_unit_tb_top.sv
module priv_sys_unit_tb_top;

  localparam logic [31:0] HANDLER = 32'h0000_0200;
  localparam logic [31:0] W_RET   = 32'h0000_007F;
  localparam logic [31:0] W_PRT   = 32'h0200_007D;
  localparam logic [31:0] W_RD    = 32'h0400_007D;
  localparam logic [31:0] W_SC6   = 32'h0060_0073;
  localparam logic [31:0] W_SC7   = 32'h0070_0073;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instValid = 1'b0;
  logic [31:0] instWord = '0, instPc = '0, regRdata = '0, ioRxData = '0;
  logic excReq = 1'b0;
  logic redirValid, wbValid, ioSend, ioRecv, illegalExc, privMode;
  logic [31:0] redirPc, wbData, ioSendData;
  logic [4:0] wbIdx;

  int checks = 0;
  int errors = 0;
  logic [31:0] pcNext = 32'h0000_1000;

  // reference model state
  logic        mPsw;
  logic [31:0] mSr [8];

  always #2 clk = ~clk;

  priv_sys_unit #(.XLEN(32), .SREG_NUM(8), .HANDLER_PC(HANDLER)) dut_i (.*);

  function automatic logic [31:0] wFrom(input logic [4:0] dst, input logic [1:0] src);
    return {7'b0000000, 3'b000, src, 5'd0, 3'b000, dst, 7'b0101111};
  endfunction
  function automatic logic [31:0] wTo(input logic [4:0] dst);
    return {7'b0000001, 13'd0, dst, 7'b0101111};
  endfunction
  function automatic logic [31:0] wJmp(input logic [4:0] rs);
    return {12'hA5C, rs, 3'b110, 5'd17, 7'b1101111};
  endfunction

  task automatic cyc(input logic v, input logic [31:0] w, input logic [31:0] rd,
                     input logic ex, input logic [31:0] rx, input string tag);
    logic eRv, eWv, eSnd, eRcv, eIll, trap, nPsw, doTo;
    logic [31:0] ePc, eWd, trapPc;
    logic [4:0] eWi;
    @(negedge clk);
    instValid = v; instWord = w; instPc = pcNext; regRdata = rd; excReq = ex; ioRxData = rx;
    eRv = 0; eWv = 0; eSnd = 0; eRcv = 0; eIll = 0; trap = 0; doTo = 0;
    ePc = '0; eWd = '0; eWi = '0; nPsw = mPsw; trapPc = pcNext;
    if (ex) trap = 1;
    else if (v) begin
      case (w)
        W_RET: if (mPsw) begin eRv = 1; ePc = mSr[0]; nPsw = 0; end
               else begin eIll = 1; trap = 1; end
        W_PRT: if (mPsw) eSnd = 1; else begin eIll = 1; trap = 1; end
        W_RD:  if (mPsw) eRcv = 1; else begin eIll = 1; trap = 1; end
        W_SC6, W_SC7: begin
          trap = 1;
          if (mPsw) eIll = 1;
          else begin trapPc = pcNext + 4; eSnd = (w == W_SC6); eRcv = (w == W_SC7); end
        end
        default: begin
          if (w[6:0] == 7'h2F && w[31:25] == 7'd0) begin
            eWv = 1; eWi = w[11:7]; eWd = mSr[w[21:20]];
          end else if (w[6:0] == 7'h2F && w[31:25] == 7'd1) doTo = (w[11:7] < 8);
          else if (w[6:0] == 7'h6F) begin eRv = 1; ePc = rd; end
        end
      endcase
    end
    if (trap) begin eRv = 1; ePc = HANDLER; nPsw = 1; end
    #1;
    checks++;
    if (redirValid !== eRv || (eRv && redirPc !== ePc) || wbValid !== eWv ||
        (eWv && (wbIdx !== eWi || wbData !== eWd)) || ioSend !== eSnd || ioRecv !== eRcv ||
        illegalExc !== eIll || privMode !== mPsw || ioSendData !== mSr[4]) begin
      errors++;
      $display("FAIL %s word=%h act rv=%b pc=%h wv=%b wi=%0d wd=%h snd=%b rcv=%b ill=%b psw=%b sd=%h exp rv=%b pc=%h wv=%b wi=%0d wd=%h snd=%b rcv=%b ill=%b psw=%b sd=%h",
               tag, w, redirValid, redirPc, wbValid, wbIdx, wbData, ioSend, ioRecv, illegalExc,
               privMode, ioSendData, eRv, ePc, eWv, eWi, eWd, eSnd, eRcv, eIll, mPsw, mSr[4]);
    end
    if (eRcv) mSr[4] = rx;
    if (trap) mSr[0] = trapPc;
    if (doTo) mSr[w[9:7]] = rd;
    mPsw = nPsw;
    pcNext = pcNext + 4;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mPsw = 1'b1;
    for (int i = 0; i < 8; i++) mSr[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state, sregs read as zero
    cyc(0, W_RET, 0, 0, 0, "R1");
    for (int i = 0; i < 4; i++) cyc(1, wFrom(5'(i + 3), 2'(i)), 0, 0, 0, "R1");
    // R8 / R7: fill and read back
    cyc(1, wTo(5'd4), 32'hA5A5_0004, 0, 0, "R8");
    cyc(1, wTo(5'd2), 32'h1234_5678, 0, 0, "R8");
    cyc(1, wFrom(5'd7, 2'd2), 0, 0, 0, "R7");
    cyc(1, wFrom(5'd31, 2'd3), 0, 0, 0, "R7");
    // R8: out-of-range index ignored (would alias to 1 and 4 if truncated)
    cyc(1, wTo(5'd9), 32'hDEAD_0009, 0, 0, "R8");
    cyc(1, wTo(5'd12), 32'hDEAD_000C, 0, 0, "R8");
    cyc(1, wFrom(5'd1, 2'd1), 0, 0, 0, "R8");
    // R4 / R5
    cyc(1, W_PRT, 0, 0, 0, "R4");
    cyc(1, W_RD, 0, 0, 32'hCAFE_F00D, "R5");
    cyc(1, W_PRT, 0, 0, 0, "R4");
    // R9 in privileged mode
    cyc(1, wJmp(5'd9), 32'h0000_4440, 0, 0, "R9");
    // R2: trap return to user
    cyc(1, wTo(5'd0), 32'h0000_3000, 0, 0, "R2");
    cyc(1, W_RET, 0, 0, 0, "R2");
    cyc(0, 0, 0, 0, 0, "R2");
    // R3: privileged words in user mode
    cyc(1, W_PRT, 0, 0, 0, "R3");
    cyc(1, wFrom(5'd2, 2'd0), 0, 0, 0, "R3");
    cyc(1, W_RET, 0, 0, 0, "R2");
    cyc(1, W_RD, 0, 0, 32'h0BAD_0BAD, "R3");
    cyc(1, W_RET, 0, 0, 0, "R2");
    cyc(1, W_RET, 0, 0, 0, "R3");
    // R6: system calls from user mode
    cyc(1, W_RET, 0, 0, 0, "R2");
    cyc(1, W_SC6, 0, 0, 0, "R6");
    cyc(1, W_RET, 0, 0, 0, "R2");
    cyc(1, W_SC7, 0, 0, 32'h7777_0007, "R6");
    cyc(1, wFrom(5'd5, 2'd0), 0, 0, 0, "R6");
    cyc(1, W_PRT, 0, 0, 0, "R6");
    cyc(1, W_SC7, 0, 0, 32'h1111_1111, "R6");
    cyc(1, W_SC6, 0, 0, 0, "R6");
    // R9 in user mode
    cyc(1, W_RET, 0, 0, 0, "R2");
    cyc(1, wJmp(5'd31), 32'h0000_8888, 0, 0, "R9");
    // R10: exception collides with instructions
    cyc(1, wTo(5'd3), 32'hFFFF_0003, 1, 0, "R10");
    cyc(1, wFrom(5'd3, 2'd3), 0, 0, 0, "R10");
    cyc(1, W_PRT, 0, 1, 0, "R10");
    cyc(1, W_RET, 0, 1, 0, "R10");
    cyc(0, 0, 0, 1, 0, "R10");
    // R11: idle and unknown words
    cyc(0, W_RET, 0, 0, 0, "R11");
    cyc(0, wTo(5'd4), 32'h5555_5555, 0, 0, "R11");
    cyc(1, 32'h0000_0033, 32'h9999_9999, 0, 0, "R11");
    cyc(1, {7'b0000010, 13'd0, 5'd4, 7'b0101111}, 32'h9999_9999, 0, 0, "R11");
    cyc(1, W_PRT, 0, 0, 0, "R11");
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] w;
      int k;
      k = $urandom_range(0, 11);
      case (k)
        0: w = W_RET; 1: w = W_PRT; 2: w = W_RD; 3: w = W_SC6; 4: w = W_SC7;
        5: w = wFrom(5'($urandom_range(0, 31)), 2'($urandom_range(0, 3)));
        6, 7: w = wTo(5'($urandom_range(0, 11)));
        8: w = wJmp(5'($urandom_range(0, 31)));
        9: w = W_RET;
        default: w = $urandom;
      endcase
      cyc(($urandom_range(0, 7) != 0), w, $urandom, ($urandom_range(0, 15) == 0), $urandom, "MIX");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule